// File: doc/BRIEF.md
# Branch Resolution and Next-PC Unit

This block owns the program counter of a small 16-bit processor and decides, every cycle, where the next instruction fetch comes from. The decoder supplies a branch-request flag, a 3-bit branch-kind code and two immediate offsets. The flag logic supplies the four condition flags. The block works out whether the branch condition holds. If it does, the PC moves to a PC-relative target. If it does not, the PC advances by one.

The taken/not-taken decision is combinational and is also brought out on a port, so the rest of the pipeline can flush on it. The PC itself is a register with a synchronous, active-high clear. The target is the current PC plus either a sign-extended 8-bit offset or a sign-extended 11-bit offset, chosen by a one-bit select. All PC arithmetic wraps modulo 2^16.

The block has no multi-state sequencing. Its only state is the PC register, which makes two named transitions. RESET_CLEAR forces the PC to 0. Otherwise STEP loads the next-PC value: either SEQUENTIAL (PC+1) or BRANCH (PC+offset).

Top module: `pc_ctrl_unit`

## Requirements
- R1: While `rst` is 1 at a rising clock edge, the PC becomes 0 after that edge.
- R2: When `taken` is 0, each rising edge loads PC+1 into the PC.
- R3: When `br_req` is 0, `taken` is 0 whatever `br_kind` and `cc` are.
- R4: With `br_req`=1 and `br_kind`=3'b000 (always), `taken` is 1 for every flag value.
- R5: With `br_req`=1 and `br_kind`=3'b001 (equal), `taken` equals the Z flag, `cc[2]`.
- R6: With `br_req`=1 and `br_kind`=3'b010 (not equal), `taken` equals the inverse of `cc[2]`.
- R7: With `br_req`=1 and `br_kind`=3'b011 (signed less than), `taken` is 1 exactly when N (`cc[3]`) differs from V (`cc[0]`).
- R8: With `br_req`=1 and `br_kind`=3'b100 (signed greater or equal), `taken` is 1 exactly when N equals V. The C flag (`cc[1]`) affects no branch kind.
- R9: The `br_kind` codes 3'b101, 3'b110 and 3'b111 are never taken.
- R10: On a taken branch, the next PC is PC + sign-extended `imm8` when `use_long` is 0, and PC + sign-extended `imm11` when `use_long` is 1.
- R11: The PC wraps modulo 2^16 on both the sequential path and the branch path.
- R12: `rst` takes priority over a taken branch in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high clear of the PC |
| br_req | input | 1 | 1 when the current instruction is a branch |
| br_kind | input | 3 | Branch condition code (000 always, 001 eq, 010 ne, 011 lt, 100 ge) |
| cc | input | 4 | Flags {N, Z, C, V}, bit 3 down to bit 0 |
| use_long | input | 1 | 1 selects the 11-bit offset, 0 the 8-bit offset |
| imm8 | input | 8 | Short signed branch offset |
| imm11 | input | 11 | Long signed branch offset |
| taken | output | 1 | Branch decision for the current cycle |
| pc | output | 16 | Current program counter |

## Verification
A reset and a taken branch can fall on the same edge. The bench provokes this by raising `rst` while an always-kind branch with a large offset is requested. The case is judged as correct only if the PC reads 0 afterwards and not the branch target. A wrap can also coincide with a branch or a sequential step. To cover this, the bench first steers the PC near 0xFFFF and near 0x0000. It then takes a forward branch and a backward branch and makes a plain step, and compares each result against modulo-2^16 arithmetic done in the bench.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    typedef enum logic [2:0] {
        BK_ALWAYS = 3'd0,
        BK_EQ     = 3'd1,
        BK_NE     = 3'd2,
        BK_LT     = 3'd3,
        BK_GE     = 3'd4
    } br_kind_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic carry;
        logic ovf;
    } flags_t;

endpackage

// File: rtl/pcu_branch_eval.sv
module pcu_branch_eval
    import pcu_pkg::*;
#(
    parameter int KIND_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [KIND_W-1:0] kind,
    input  flags_t            flags,
    output logic              take
);

    logic cond_true;

    always_comb begin
        cond_true = 1'b0;
        unique case (kind)
            BK_ALWAYS: cond_true = 1'b1;
            BK_EQ:     cond_true = flags.zero;
            BK_NE:     cond_true = !flags.zero;
            BK_LT:     cond_true = flags.neg ^ flags.ovf;
            BK_GE:     cond_true = !(flags.neg ^ flags.ovf);
            default:   cond_true = 1'b0;
        endcase
    end

    assign take = req & cond_true;

    AST_NO_REQ_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
        !req |-> !take); // R3

    AST_RESERVED_IDLE: assert property (@(posedge clk) disable iff (rst)
        (kind > KIND_W'(4)) |-> !take); // R9

    AST_ALWAYS_TAKES: assert property (@(posedge clk) disable iff (rst)
        (req && kind == KIND_W'(0)) |-> take); // R4

endmodule

// File: rtl/pcu_target_gen.sv
module pcu_target_gen #(
    parameter int PC_W    = 16,
    parameter int SHORT_W = 8,
    parameter int LONG_W  = 11
) (
    input  logic [PC_W-1:0]    cur_pc,
    input  logic [SHORT_W-1:0] off_short,
    input  logic [LONG_W-1:0]  off_long,
    input  logic               sel_long,
    output logic [PC_W-1:0]    seq_pc,
    output logic [PC_W-1:0]    br_pc
);

    logic [PC_W-1:0] ext_short;
    logic [PC_W-1:0] ext_long;

    generate
        if (SHORT_W < PC_W) begin : g_short_ext
            assign ext_short = {{(PC_W-SHORT_W){off_short[SHORT_W-1]}}, off_short};
        end else begin : g_short_cut
            assign ext_short = off_short[PC_W-1:0];
        end
        if (LONG_W < PC_W) begin : g_long_ext
            assign ext_long = {{(PC_W-LONG_W){off_long[LONG_W-1]}}, off_long};
        end else begin : g_long_cut
            assign ext_long = off_long[PC_W-1:0];
        end
    endgenerate

    assign seq_pc = cur_pc + PC_W'(1);
    assign br_pc  = cur_pc + (sel_long ? ext_long : ext_short);

endmodule

// File: rtl/pcu_pc_reg.sv
module pcu_pc_reg #(
    parameter int PC_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            take,
    input  logic [PC_W-1:0] seq_pc,
    input  logic [PC_W-1:0] br_pc,
    output logic [PC_W-1:0] pc_q
);

    typedef enum logic [1:0] {
        PCS_RESET_CLEAR = 2'd0,
        PCS_SEQUENTIAL  = 2'd1,
        PCS_BRANCH      = 2'd2
    } pc_move_e;

    pc_move_e        move;
    logic [PC_W-1:0] pc_d;
    logic            rst_q;

    always_comb begin
        if (rst)       move = PCS_RESET_CLEAR;
        else if (take) move = PCS_BRANCH;
        else           move = PCS_SEQUENTIAL;
    end

    always_comb begin
        pc_d = '0;
        unique case (move)
            PCS_RESET_CLEAR: pc_d = '0;
            PCS_SEQUENTIAL:  pc_d = seq_pc;
            PCS_BRANCH:      pc_d = br_pc;
            default:         pc_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        pc_q <= pc_d;
    end

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst_q == 1'b1) begin
            AST_RESET_CLEARS: assert (pc_q == '0); // R1
        end
    end

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        !take |=> (pc_q == $past(pc_q) + PC_W'(1))); // R2

endmodule

// File: rtl/pc_ctrl_unit.sv
module pc_ctrl_unit
    import pcu_pkg::*;
#(
    parameter int PC_W    = 16,
    parameter int KIND_W  = 3,
    parameter int SHORT_W = 8,
    parameter int LONG_W  = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               br_req,
    input  logic [KIND_W-1:0]  br_kind,
    input  logic [3:0]         cc,
    input  logic               use_long,
    input  logic [SHORT_W-1:0] imm8,
    input  logic [LONG_W-1:0]  imm11,
    output logic               taken,
    output logic [PC_W-1:0]    pc
);

    localparam int SH_PAD = PC_W - SHORT_W;
    localparam int LG_PAD = PC_W - LONG_W;

    flags_t          flags;
    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] br_pc;

    assign flags = flags_t'(cc);

    pcu_branch_eval #(.KIND_W(KIND_W)) u_eval (
        .clk   (clk),
        .rst   (rst),
        .req   (br_req),
        .kind  (br_kind),
        .flags (flags),
        .take  (taken)
    );

    pcu_target_gen #(.PC_W(PC_W), .SHORT_W(SHORT_W), .LONG_W(LONG_W)) u_tgt (
        .cur_pc    (pc),
        .off_short (imm8),
        .off_long  (imm11),
        .sel_long  (use_long),
        .seq_pc    (seq_pc),
        .br_pc     (br_pc)
    );

    pcu_pc_reg #(.PC_W(PC_W)) u_pc (
        .clk    (clk),
        .rst    (rst),
        .take   (taken),
        .seq_pc (seq_pc),
        .br_pc  (br_pc),
        .pc_q   (pc)
    );

    AST_SHORT_TARGET: assert property (@(posedge clk) disable iff (rst)
        (taken && !use_long) |=>
        (pc == $past(pc) + {{SH_PAD{$past(imm8[SHORT_W-1])}}, $past(imm8)})); // R10

    AST_LONG_TARGET: assert property (@(posedge clk) disable iff (rst)
        (taken && use_long) |=>
        (pc == $past(pc) + {{LG_PAD{$past(imm11[LONG_W-1])}}, $past(imm11)})); // R10

endmodule

// File: tb/sim_pc_ctrl_unit.sv
module sim_pc_ctrl_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        br_req;
    logic [2:0]  br_kind;
    logic [3:0]  cc;
    logic        use_long;
    logic [7:0]  imm8;
    logic [10:0] imm11;
    logic        taken;
    logic [15:0] pc;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] exp_pc;

    always #4 clk = ~clk;

    pc_ctrl_unit u0 (
        .clk(clk), .rst(rst), .br_req(br_req), .br_kind(br_kind), .cc(cc),
        .use_long(use_long), .imm8(imm8), .imm11(imm11), .taken(taken), .pc(pc)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic model_take(input logic r, input logic [2:0] k, input logic [3:0] f);
        logic nf, zf, vf;
        nf = f[3]; zf = f[2]; vf = f[0];
        if (!r) return 1'b0;
        case (k)
            3'd0: return 1'b1;
            3'd1: return zf;
            3'd2: return !zf;
            3'd3: return nf != vf;
            3'd4: return nf == vf;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string tag_of(input logic r, input logic [2:0] k);
        if (!r) return "R3";
        case (k)
            3'd0: return "R4";
            3'd1: return "R5";
            3'd2: return "R6";
            3'd3: return "R7";
            3'd4: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic idle_inputs();
        br_req = 1'b0; br_kind = 3'd0; cc = 4'd0; use_long = 1'b0;
        imm8 = 8'd0; imm11 = 11'd0;
    endtask

    // one step: inputs driven at negedge, output sampled after next posedge
    task automatic step_and_check(input string req);
        logic [15:0] off;
        off = use_long ? {{5{imm11[10]}}, imm11} : {{8{imm8[7]}}, imm8};
        #1;
        check(req, {15'd0, taken}, {15'd0, model_take(br_req, br_kind, cc)});
        exp_pc = model_take(br_req, br_kind, cc) ? exp_pc + off : exp_pc + 16'd1;
        @(posedge clk); #1;
        check(req, pc, exp_pc);
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        idle_inputs();
        rst = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        check("R1", pc, 16'd0);
        @(negedge clk);
        rst = 1'b0;
        exp_pc = 16'd0;
    endtask

    task automatic t_sequential();
        idle_inputs();
        for (int i = 0; i < 5; i++) step_and_check("R2");
    endtask

    task automatic t_cc_sweep();
        for (int r = 0; r < 2; r++)
            for (int k = 0; k < 8; k++)
                for (int f = 0; f < 16; f++) begin
                    br_req = r[0]; br_kind = k[2:0]; cc = f[3:0];
                    use_long = 1'b0;
                    imm8 = (f[0]) ? 8'hF9 : 8'h05;
                    step_and_check(tag_of(r[0], k[2:0]));
                end
        idle_inputs();
    endtask

    task automatic t_targets();
        br_req = 1'b1; br_kind = 3'd0; cc = 4'd0;
        use_long = 1'b1; imm11 = 11'h3FF; imm8 = 8'h80; step_and_check("R10");
        use_long = 1'b1; imm11 = 11'h400; imm8 = 8'h7F; step_and_check("R10");
        use_long = 1'b0; imm11 = 11'h123; imm8 = 8'h80; step_and_check("R10");
        use_long = 1'b0; imm11 = 11'h7FF; imm8 = 8'h7F; step_and_check("R10");
        idle_inputs();
    endtask

    task automatic t_wrap();
        // steer near top with long forward jumps, then step across 0xFFFF
        br_req = 1'b1; br_kind = 3'd0; use_long = 1'b1;
        while (exp_pc < 16'hFC00 && exp_pc >= 16'h0010) begin
            imm11 = 11'h3FF; step_and_check("R11");
        end
        br_kind = 3'd0; use_long = 1'b1; imm11 = 11'h3FF;
        while (exp_pc < 16'hFC00) step_and_check("R11");
        use_long = 1'b0; imm8 = 8'h7F;
        while (exp_pc >= 16'hFC00) step_and_check("R11");
        idle_inputs();
        step_and_check("R11");
        // backward branch across zero
        br_req = 1'b1; br_kind = 3'd1; cc = 4'b0100; use_long = 1'b1; imm11 = 11'h400;
        step_and_check("R11");
        idle_inputs();
    endtask

    task automatic t_reset_vs_branch();
        br_req = 1'b1; br_kind = 3'd0; use_long = 1'b1; imm11 = 11'h2AB;
        rst = 1'b1;
        @(posedge clk); #1;
        check("R12", pc, 16'd0);
        @(negedge clk);
        rst = 1'b0; idle_inputs();
        exp_pc = 16'd0;
        step_and_check("R12");
    endtask

    initial begin
        rst = 1'b1;
        idle_inputs();
        exp_pc = 16'd0;
        t_reset();
        t_sequential();
        t_cc_sweep();
        t_targets();
        t_wrap();
        t_reset_vs_branch();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule